// File: doc/BRIEF.md
# Counter-Keyed Pad Prefetch Queue

This block encrypts and decrypts cache lines on a snooped shared bus with one-time pads. Every agent on the bus keeps a 64-bit transaction counter. The counter is loaded once with a secret starting value after boot. It then steps by one for each completed bus transaction the agent observes, so all agents hold the same value at all times. A pad is a keyed function of a 256-bit process key and that counter value. XORing the pad onto a line encrypts it, and XORing the same pad onto the ciphertext restores the line.

Computing a pad takes several cycles and sits on the transfer's critical path, so the block works ahead. A generator fills a small queue with pads for the current counter value and the values that follow it. Each queue slot carries the counter value it was built for. When the agent is granted the bus, or receives a line, it raises a transfer strobe. The block then selects the slot whose tag equals the live counter value and returns the line XORed with that pad one cycle later.

If no slot matches, the line is held and a miss flag is raised until the generator delivers the pad. Slots whose value the counter has passed are discarded. The generator never builds a pad for a value already passed.

Top module: `pad_prefetch_queue`

## Requirements
- R1: After reset, `out_valid_o` and `miss_o` are low, and they stay low while no transfer strobe is given.
- R2: A seed load sets the counter to `seed_i`. Each `snoop_i` pulse adds one, wrapping modulo 2^64. A transfer uses the counter value held in the cycle its strobe is sampled.
- R3: The pad P(key, c) is built one 64-bit word at a time. Word w occupies bits 64w+63 down to 64w. Start from x = c XOR key word (w mod 4) XOR ((w+1) × 0x9E3779B97F4A7C15) mod 2^64. Then apply x ^= x>>31, then x = x × 0xBF58476D1CE4E5B9 mod 2^64, then x ^= x>>27.
- R4: On a transfer whose pad is queued, `out_valid_o` is high for exactly the next cycle, `miss_o` stays low, and `data_o` = `data_i` XOR P(key, counter).
- R5: A transfer with the ciphertext as `data_i` at the same counter value returns the plaintext.
- R6: On a transfer whose pad is not queued, `miss_o` rises in the next cycle and stays high until the cycle in which `out_valid_o` pulses. At that pulse `miss_o` is low and `data_o` holds the correctly padded line.
- R7: A seed load discards all queued and in-flight pads. A transfer in the cycle after the load misses, uses the pad of the new seed, and completes within LAT+3 cycles of its strobe.
- R8: Once the block has been idle for DEPTH+LAT+2 cycles, transfers at the next DEPTH−1 counter values each hit with no miss, each separated only by a single snoop pulse. At most one slot matches any value.
- R9: The generator never issues a pad for a value behind the counter. Stale slots are dropped, and after a burst of snoops or a wrap through zero every transfer still carries the pad of the live counter value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| key_i | input | KEY_W | Process key, held stable after a seed load |
| seed_load_i | input | 1 | Load `seed_i` into the counter and flush the queue |
| seed_i | input | 64 | Initial counter value |
| snoop_i | input | 1 | One pulse per completed bus transaction |
| xfer_i | input | 1 | Transfer strobe (bus grant for send, or line arrival for receive) |
| data_i | input | DATA_W | Line to encrypt or decrypt |
| data_o | output | DATA_W | Padded line |
| out_valid_o | output | 1 | One-cycle pulse when `data_o` is new |
| miss_o | output | 1 | Transfer waiting for its pad |

## Verification
The bench builds the block with a four-slot queue, a three-stage generator and 128-bit lines. With this configuration, filling the queue, draining it through snoop bursts and reloading the seed each take only a few cycles. That brings every path within reach: hits, post-load misses, stale-slot dropping and the counter wrapping through zero. The bench also sweeps sixteen consecutive counter values with send and receive round trips, and it computes every expected line from its own model of the pad function.

// File: rtl/padq_pkg.sv
package padq_pkg;
  localparam int unsigned CTR_W = 64;
  localparam logic [63:0] GOLD  = 64'h9E3779B97F4A7C15;
  localparam logic [63:0] MULC  = 64'hBF58476D1CE4E5B9;

  // keyed placeholder mix for one 64-bit pad word
  function automatic logic [63:0] mix_word(logic [63:0] c, logic [63:0] k,
                                           logic [63:0] idx);
    logic [63:0] x;
    x = c ^ k ^ ((idx + 64'd1) * GOLD);
    x = x ^ (x >> 31);
    x = x * MULC;
    x = x ^ (x >> 27);
    return x;
  endfunction

  // wrap-safe "a is older than b"
  function automatic logic is_behind(logic [CTR_W-1:0] a, logic [CTR_W-1:0] b);
    logic [CTR_W-1:0] d;
    d = a - b;
    return d[CTR_W-1];
  endfunction
endpackage

// File: rtl/txn_counter.sv
module txn_counter
  import padq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CTR_W-1:0] seed_i,
  input  logic             step_i,
  output logic [CTR_W-1:0] ctr_o
);
  logic [CTR_W-1:0] ctr_q, ctr_d;
  logic             ctr_en;

  always_comb begin
    ctr_en = load_i | step_i;
    ctr_d  = load_i ? seed_i : ctr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctr_q <= '0;
    else if (ctr_en) ctr_q <= ctr_d;
  end

  assign ctr_o = ctr_q;
endmodule

// File: rtl/pad_gen.sv
module pad_gen
  import padq_pkg::*;
#(
  parameter int unsigned LAT    = 4,
  parameter int unsigned DATA_W = 256,
  parameter int unsigned KEY_W  = 256,
  parameter int unsigned CW     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [KEY_W-1:0]  key_i,
  input  logic              load_i,
  input  logic [CTR_W-1:0]  seed_i,
  input  logic [CTR_W-1:0]  ctr_i,
  input  logic              room_i,
  output logic              arr_v_o,
  output logic [CTR_W-1:0]  arr_tag_o,
  output logic [DATA_W-1:0] arr_pad_o,
  output logic [CW-1:0]     inflight_o
);
  localparam int unsigned NW = DATA_W / 64;
  localparam int unsigned KW = KEY_W / 64;

  logic [CTR_W-1:0] gen_q, gen_d, cand;
  logic             issue;
  logic [LAT-1:0]   pv_q, pv_d;
  logic [CTR_W-1:0] pt_q [LAT];
  logic [CTR_W-1:0] pt_d [LAT];

  always_comb begin
    cand  = is_behind(gen_q, ctr_i) ? ctr_i : gen_q;
    issue = room_i & ~load_i;
    gen_d = load_i ? seed_i : (issue ? cand + 1'b1 : gen_q);
    pv_d[0] = issue;
    pt_d[0] = cand;
    for (int i = 1; i < LAT; i++) begin
      pv_d[i] = pv_q[i-1];
      pt_d[i] = pt_q[i-1];
    end
    if (load_i) pv_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gen_q <= '0;
      pv_q  <= '0;
    end else begin
      gen_q <= gen_d;
      pv_q  <= pv_d;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < LAT; i++) pt_q[i] <= pt_d[i];
  end

  always_comb begin
    inflight_o = '0;
    for (int i = 0; i < LAT; i++) inflight_o = inflight_o + CW'(pv_q[i]);
  end

  assign arr_tag_o = pt_q[LAT-1];
  assign arr_v_o   = pv_q[LAT-1] & ~load_i & ~is_behind(pt_q[LAT-1], ctr_i);

  for (genvar w = 0; w < NW; w++) begin : g_word
    assign arr_pad_o[64*w +: 64] =
      mix_word(pt_q[LAT-1], key_i[64*(w % KW) +: 64], 64'(w));
  end

  // R9
  no_stale_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pv_q[0] |-> !is_behind(pt_q[0], $past(ctr_i)));
endmodule

// File: rtl/pad_store.sv
module pad_store
  import padq_pkg::*;
#(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned DATA_W = 256,
  parameter int unsigned CW     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush_i,
  input  logic [CTR_W-1:0]  ctr_i,
  input  logic              wr_v_i,
  input  logic [CTR_W-1:0]  wr_tag_i,
  input  logic [DATA_W-1:0] wr_pad_i,
  input  logic [CTR_W-1:0]  q_tag_i,
  output logic              hit_o,
  output logic [DATA_W-1:0] hit_pad_o,
  output logic [CW-1:0]     count_o
);
  logic [DEPTH-1:0]  val_q, val_d, match, wsel;
  logic [CTR_W-1:0]  tag_q [DEPTH];
  logic [DATA_W-1:0] pad_q [DEPTH];
  logic              found;

  always_comb begin
    wsel  = '0;
    found = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      if (!val_q[i] && !found) begin
        wsel[i] = wr_v_i;
        found   = 1'b1;
      end
    end
    for (int i = 0; i < DEPTH; i++)
      val_d[i] = (val_q[i] & ~is_behind(tag_q[i], ctr_i)) | wsel[i];
    if (flush_i) val_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) val_q <= '0;
    else        val_q <= val_d;
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (wsel[i]) begin
        tag_q[i] <= wr_tag_i;
        pad_q[i] <= wr_pad_i;
      end
    end
  end

  always_comb begin
    hit_pad_o = '0;
    count_o   = '0;
    for (int i = 0; i < DEPTH; i++) begin
      match[i]  = val_q[i] && (tag_q[i] == q_tag_i);
      hit_pad_o = hit_pad_o | (match[i] ? pad_q[i] : '0);
      count_o   = count_o + CW'(val_q[i]);
    end
    hit_o = |match;
  end

  // R8
  one_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match));
endmodule

// File: rtl/pad_prefetch_queue.sv
module pad_prefetch_queue
  import padq_pkg::*;
#(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned LAT    = 4,
  parameter int unsigned DATA_W = 256,
  parameter int unsigned KEY_W  = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [KEY_W-1:0]  key_i,
  input  logic              seed_load_i,
  input  logic [63:0]       seed_i,
  input  logic              snoop_i,
  input  logic              xfer_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o,
  output logic              out_valid_o,
  output logic              miss_o
);
  localparam int unsigned CW    = $clog2(DEPTH + LAT + 1) + 1;
  localparam int unsigned BOUND = 2 * LAT + DEPTH + 4;
  localparam int unsigned WW    = $clog2(BOUND + 2) + 1;

  logic [CTR_W-1:0]  ctr, q_tag, ptag_q, ptag_d, arr_tag;
  logic [DATA_W-1:0] pdat_q, pdat_d, arr_pad, hit_pad, out_src, data_q;
  logic [CW-1:0]     store_cnt, inflight;
  logic              room, hit, arr_v;
  logic              pend_q, pend_d, outv_q, out_en;

  txn_counter u_ctr (
    .clk(clk), .rst_n(rst_n), .load_i(seed_load_i), .seed_i(seed_i),
    .step_i(snoop_i), .ctr_o(ctr)
  );

  assign room = (store_cnt + inflight) < CW'(DEPTH);

  pad_gen #(.LAT(LAT), .DATA_W(DATA_W), .KEY_W(KEY_W), .CW(CW)) u_gen (
    .clk(clk), .rst_n(rst_n), .key_i(key_i), .load_i(seed_load_i),
    .seed_i(seed_i), .ctr_i(ctr), .room_i(room), .arr_v_o(arr_v),
    .arr_tag_o(arr_tag), .arr_pad_o(arr_pad), .inflight_o(inflight)
  );

  assign q_tag = pend_q ? ptag_q : ctr;

  pad_store #(.DEPTH(DEPTH), .DATA_W(DATA_W), .CW(CW)) u_store (
    .clk(clk), .rst_n(rst_n), .flush_i(seed_load_i), .ctr_i(ctr),
    .wr_v_i(arr_v), .wr_tag_i(arr_tag), .wr_pad_i(arr_pad),
    .q_tag_i(q_tag), .hit_o(hit), .hit_pad_o(hit_pad), .count_o(store_cnt)
  );

  always_comb begin
    pend_d  = pend_q;
    ptag_d  = ptag_q;
    pdat_d  = pdat_q;
    out_en  = 1'b0;
    out_src = data_i;
    if (pend_q) begin
      if (hit) begin
        out_en  = 1'b1;
        out_src = pdat_q;
        pend_d  = 1'b0;
      end
    end else if (xfer_i) begin
      if (hit) begin
        out_en = 1'b1;
      end else begin
        pend_d = 1'b1;
        ptag_d = ctr;
        pdat_d = data_i;
      end
    end
    if (seed_load_i && !out_en) pend_d = (xfer_i && !pend_q) ? 1'b1 : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      outv_q <= 1'b0;
    end else begin
      pend_q <= pend_d;
      outv_q <= out_en;
    end
  end

  always_ff @(posedge clk) begin
    if (out_en) data_q <= out_src ^ hit_pad;
    if (!pend_q && xfer_i) begin
      ptag_q <= ptag_d;
      pdat_q <= pdat_d;
    end
  end

  assign data_o      = data_q;
  assign out_valid_o = outv_q;
  assign miss_o      = pend_q;

  // wait counter for the miss window check
  logic [WW-1:0] wcnt_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      wcnt_q <= '0;
    else if (pend_q) wcnt_q <= wcnt_q + 1'b1;
    else             wcnt_q <= '0;
  end

  // R6
  miss_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wcnt_q <= WW'(BOUND));
  // R6
  miss_end_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(miss_o) && !$past(seed_load_i)) |-> (out_valid_o && !miss_o));
  // R4
  hit_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_i && !pend_q && hit) |=> (out_valid_o && !miss_o));
  // R2
  no_snoop_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |-> !snoop_i);
endmodule

// File: tb/pad_prefetch_queue_tb.sv
module pad_prefetch_queue_tb;
  localparam int unsigned DEPTH = 4;
  localparam int unsigned LAT   = 3;
  localparam int unsigned DW    = 128;
  localparam int unsigned KW    = 256;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [KW-1:0] key = 256'h0f1e2d3c4b5a6978_8796a5b4c3d2e1f0_1122334455667788_99aabbccddeeff00;
  logic          load = 1'b0, snoop = 1'b0, xfer = 1'b0;
  logic [63:0]   seed = '0;
  logic [DW-1:0] din = '0, dout;
  logic          ovalid, miss;

  int checks = 0, fails = 0, cyc = 0;
  logic [63:0] exp_ctr = '0;

  always #2 clk = ~clk;

  pad_prefetch_queue #(.DEPTH(DEPTH), .LAT(LAT), .DATA_W(DW), .KEY_W(KW)) u_dut (
    .clk(clk), .rst_n(rst_n), .key_i(key), .seed_load_i(load), .seed_i(seed),
    .snoop_i(snoop), .xfer_i(xfer), .data_i(din), .data_o(dout),
    .out_valid_o(ovalid), .miss_o(miss)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      fails = fails + 1;
      $display("FAIL watchdog: act=%0d exp=<100000 cycles", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  function automatic logic [DW-1:0] ref_pad(logic [63:0] c);
    logic [DW-1:0] p;
    logic [63:0] x;
    for (int w = 0; w < DW / 64; w++) begin
      x = 64'(w + 1) * 64'h9E3779B97F4A7C15;
      x = x ^ c ^ key[64*(w % 4) +: 64];
      x = x ^ (x >> 31);
      x = x * 64'hBF58476D1CE4E5B9;
      x = x ^ (x >> 27);
      p[64*w +: 64] = x;
    end
    return p;
  endfunction

  task automatic check(input bit ok, input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    checks = checks + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic do_load(input logic [63:0] s);
    @(negedge clk); load = 1'b1; seed = s;
    @(negedge clk); load = 1'b0;
    exp_ctr = s;
  endtask

  task automatic do_snoop(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); snoop = 1'b1;
      exp_ctr = exp_ctr + 1;
    end
    @(negedge clk); snoop = 1'b0;
  endtask

  // mode 0: any, 1: must hit, 2: must miss
  task automatic do_xfer(input logic [DW-1:0] d, input int mode, input string req,
                         output logic [DW-1:0] got);
    int waited;
    @(negedge clk); xfer = 1'b1; din = d;
    @(negedge clk); xfer = 1'b0;
    if (mode == 1)
      check(ovalid && !miss, req, {ovalid, miss}, 2'b10);
    if (mode == 2)
      check(!ovalid && miss, req, {ovalid, miss}, 2'b01);
    waited = 0;
    while (!ovalid && waited < 40) begin
      @(negedge clk);
      waited++;
    end
    if (mode == 2)
      check(waited <= LAT + 2 && !miss, "R7 miss latency", waited, LAT + 2);
    check(ovalid && !miss, "R6 output pulse", {ovalid, miss}, 2'b10);
    check(dout == (d ^ ref_pad(exp_ctr)), req, dout, d ^ ref_pad(exp_ctr));
    got = dout;
    @(negedge clk);
    check(!ovalid, "R4 single pulse", ovalid, 0);
  endtask

  initial begin
    logic [DW-1:0] ct, pt, d;
    repeat (3) @(negedge clk);
    check(!ovalid && !miss, "R1 reset state", {ovalid, miss}, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(!ovalid && !miss, "R1 idle after reset", {ovalid, miss}, 0);

    do_load(64'h0123_4567_89ab_cdef);
    do_xfer({4{32'hdeadbeef}}, 2, "R7 first transfer after load", ct);

    repeat (DEPTH + LAT + 4) @(negedge clk);
    for (int k = 0; k < 16; k++) begin
      d = {8{k[15:0]}} ^ {DW{k[0]}};
      do_xfer(d, 1, "R4 R3 sweep send", ct);
      do_xfer(ct, 1, "R5 receive", pt);
      check(pt == d, "R5 round trip", pt, d);
      do_snoop(1);
    end

    repeat (DEPTH + LAT + 4) @(negedge clk);
    for (int k = 0; k < DEPTH - 1; k++) begin
      do_snoop(1);
      do_xfer({DW{1'b1}} >> k, 1, "R8 prefetched run", ct);
    end

    do_snoop(10);
    do_xfer({2{64'h5555_aaaa_0f0f_f0f0}}, 0, "R9 after burst R2", ct);
    do_snoop(2 * DEPTH + 1);
    do_xfer('0, 0, "R9 pad equals plain pad", ct);

    do_load(64'hffff_ffff_ffff_fffd);
    repeat (DEPTH + LAT + 4) @(negedge clk);
    for (int k = 0; k < 6; k++) begin
      do_xfer(DW'(k * 7 + 3), 1, "R2 wrap R9", ct);
      do_snoop(1);
    end

    repeat (DEPTH + LAT + 4) @(negedge clk);
    do_load(64'h7777_0000_1234_5678);
    do_xfer({4{32'h0badf00d}}, 2, "R7 reload flush", ct);
    do_xfer(ct, 1, "R5 R7 receive after reload", pt);
    check(pt == {4{32'h0badf00d}}, "R5 reload round trip", pt, {4{32'h0badf00d}});

    repeat (4) @(negedge clk);
    check(!ovalid && !miss, "R1 quiet at end", {ovalid, miss}, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule